// File: doc/BRIEF.md
# VSync Interrupt Gate

This block decides, for one display source, whether a frame-boundary (VSync) event should interrupt the host. Each overlay plane carries a programmable interrupt threshold expressed as a present ID. On every VSync the block compares the present ID each plane is currently scanning out against that plane's threshold. It raises a single interrupt pulse when at least one plane asks for it. Two threshold values are reserved: all ones means "stay quiet until rewritten", and zero means "interrupt on every VSync".

On top of the per-plane filter sits a global interrupt enable with a two-stage shutdown. A keep-phase disable silences interrupts but leaves the VSync phase generator running, so a later re-enable lands on the same timing. Only a separate no-phase disable stops the generator, and the `phase_active` output reports that. Thresholds written while interrupts are disabled are kept and take effect once interrupts are enabled again.

Top module: `vsync_irq_gate`

## Requirements
- R1: After synchronous reset `irq` and `phase_active` are 0, interrupts are disabled, and every plane threshold holds the all-ones value.
- R2: A plane whose threshold is all ones (every bit 1) never requests an interrupt, whatever its scanned present ID.
- R3: A plane whose threshold is zero requests an interrupt on every VSync.
- R4: For any other threshold, a plane requests an interrupt when its scanned present ID is greater than or equal to the threshold (unsigned compare).
- R5: With several planes, an interrupt is raised when any plane requests one.
- R6: `irq` is a one-cycle pulse. It is high in the cycle after a cycle with `vsync` high, and only when interrupts are enabled and a plane requests one.
- R7: While interrupts are disabled, no `irq` is raised. Threshold writes made meanwhile are stored and apply after re-enable.
- R8: `irq_en_cmd` enables interrupts and sets `phase_active`. `dis_keep_cmd` disables interrupts and leaves `phase_active` unchanged. `dis_nophase_cmd` disables interrupts and clears `phase_active`. Priority when several are high: no-phase, then keep-phase, then enable.
- R9: A threshold write in the same cycle as `vsync` is compared using the newly written value.
- R10: Enable and disable commands take effect from the next cycle, so a VSync in the command's own cycle is judged with the previous enable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_en_cmd | input | 1 | Enable interrupts and start phase |
| dis_keep_cmd | input | 1 | Disable interrupts, keep phase running |
| dis_nophase_cmd | input | 1 | Disable interrupts and stop phase |
| tgt_wr | input | NUM_PLANES | Per-plane threshold write strobe |
| tgt_data | input | NUM_PLANES*ID_W | Per-plane threshold values, plane 0 in the low bits |
| scan_id | input | NUM_PLANES*ID_W | Per-plane currently scanned present ID, plane 0 in the low bits |
| vsync | input | 1 | One-cycle VSync event |
| irq | output | 1 | Registered interrupt pulse |
| phase_active | output | 1 | VSync phase generator running |

## Verification
The compare path is driven through a vector table. It covers both sentinels, thresholds just above, equal to and below the scanned ID, the largest non-sentinel threshold, and mixes where only one of two planes asks. This separates the any-plane OR from a single-plane decision and exposes an off-by-one in the greater-or-equal test. Writes arrive in the same cycle as the VSync, so a design that compares against the stale threshold gives a different answer. Directed sequences then step through keep-phase disable, writes made while disabled, re-enable with a coincident VSync, no-phase disable and competing commands. These show whether stored thresholds survive, whether commands wait a cycle, and which command wins.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  typedef enum logic [1:0] {
    PH_OFF       = 2'd0,
    PH_RUN_IRQ   = 2'd1,
    PH_RUN_QUIET = 2'd2
  } phase_state_e;
endpackage

// File: rtl/vsg_target_reg.sv
module vsg_target_reg #(
  parameter int ID_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [ID_W-1:0] wdata,
  output logic [ID_W-1:0] eff_target
);
  localparam logic [ID_W-1:0] QUIET = {ID_W{1'b1}};
  logic [ID_W-1:0] tgt_q;

  always_ff @(posedge clk) begin
    if (rst)     tgt_q <= QUIET;
    else if (wr) tgt_q <= wdata;
  end

  // same-cycle write is seen by the compare
  assign eff_target = wr ? wdata : tgt_q;
endmodule

// File: rtl/vsg_plane_cmp.sv
module vsg_plane_cmp #(
  parameter int ID_W = 16
) (
  input  logic [ID_W-1:0] target,
  input  logic [ID_W-1:0] scanned,
  output logic            need
);
  localparam logic [ID_W-1:0] QUIET = {ID_W{1'b1}};
  localparam logic [ID_W-1:0] EVERY = '0;

  always_comb begin
    if (target == QUIET)      need = 1'b0;
    else if (target == EVERY) need = 1'b1;
    else                      need = (scanned >= target);
  end
endmodule

// File: rtl/vsg_phase_ctl.sv
module vsg_phase_ctl
  import vsg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en_cmd,
  input  logic keep_cmd,
  input  logic nophase_cmd,
  output logic irq_en,
  output logic phase_on
);
  phase_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (nophase_cmd)   st_d = PH_OFF;
    else if (keep_cmd) st_d = (st_q == PH_RUN_IRQ) ? PH_RUN_QUIET : st_q;
    else if (en_cmd)   st_d = PH_RUN_IRQ;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= PH_OFF;
    else     st_q <= st_d;
  end

  assign irq_en   = (st_q == PH_RUN_IRQ);
  assign phase_on = (st_q != PH_OFF);
endmodule

// File: rtl/vsync_irq_gate.sv
module vsync_irq_gate #(
  parameter int NUM_PLANES = 2,
  parameter int ID_W       = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       irq_en_cmd,
  input  logic                       dis_keep_cmd,
  input  logic                       dis_nophase_cmd,
  input  logic [NUM_PLANES-1:0]      tgt_wr,
  input  logic [NUM_PLANES*ID_W-1:0] tgt_data,
  input  logic [NUM_PLANES*ID_W-1:0] scan_id,
  input  logic                       vsync,
  output logic                       irq,
  output logic                       phase_active
);
  logic [NUM_PLANES-1:0] plane_need;
  logic                  irq_en_q;
  logic                  irq_q;

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    logic [ID_W-1:0] eff_tgt;

    vsg_target_reg #(.ID_W(ID_W)) u_tgt (
      .clk        (clk),
      .rst        (rst),
      .wr         (tgt_wr[p]),
      .wdata      (tgt_data[p*ID_W +: ID_W]),
      .eff_target (eff_tgt)
    );

    vsg_plane_cmp #(.ID_W(ID_W)) u_cmp (
      .target  (eff_tgt),
      .scanned (scan_id[p*ID_W +: ID_W]),
      .need    (plane_need[p])
    );
  end

  vsg_phase_ctl u_phase (
    .clk         (clk),
    .rst         (rst),
    .en_cmd      (irq_en_cmd),
    .keep_cmd    (dis_keep_cmd),
    .nophase_cmd (dis_nophase_cmd),
    .irq_en      (irq_en_q),
    .phase_on    (phase_active)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= vsync & irq_en_q & (|plane_need);
  end

  assign irq = irq_q;
endmodule

// File: rtl/vsync_irq_gate_chk.sv
module vsync_irq_gate_chk (
  input logic clk,
  input logic rst,
  input logic irq_en_cmd,
  input logic dis_keep_cmd,
  input logic dis_nophase_cmd,
  input logic vsync,
  input logic irq,
  input logic irq_en,
  input logic phase_active
);
  // R6
  irq_after_vsync_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(vsync));

  // R7
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en));

  // R8
  nophase_stops_chk: assert property (@(posedge clk) disable iff (rst)
    dis_nophase_cmd |=> !phase_active);

  // R8
  keep_holds_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (dis_keep_cmd && !dis_nophase_cmd) |=> $stable(phase_active));

  // R8
  enable_starts_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_en_cmd && !dis_keep_cmd && !dis_nophase_cmd) |=> (phase_active && irq_en));

  // R8
  enable_implies_phase_chk: assert property (@(posedge clk) disable iff (rst)
    irq_en |-> phase_active);
endmodule

bind vsync_irq_gate vsync_irq_gate_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .irq_en_cmd      (irq_en_cmd),
  .dis_keep_cmd    (dis_keep_cmd),
  .dis_nophase_cmd (dis_nophase_cmd),
  .vsync           (vsync),
  .irq             (irq),
  .irq_en          (irq_en_q),
  .phase_active    (phase_active)
);

// File: tb/vsync_irq_gate_tb.sv
module vsync_irq_gate_tb;
  localparam int P = 2;
  localparam int W = 16;
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq_en_cmd = 0, dis_keep_cmd = 0, dis_nophase_cmd = 0;
  logic [P-1:0]   tgt_wr = '0;
  logic [P*W-1:0] tgt_data = '0;
  logic [P*W-1:0] scan_id = '0;
  logic vsync = 0;
  logic irq, phase_active;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  vsync_irq_gate #(.NUM_PLANES(P), .ID_W(W)) u_dut (
    .clk(clk), .rst(rst), .irq_en_cmd(irq_en_cmd), .dis_keep_cmd(dis_keep_cmd),
    .dis_nophase_cmd(dis_nophase_cmd), .tgt_wr(tgt_wr), .tgt_data(tgt_data),
    .scan_id(scan_id), .vsync(vsync), .irq(irq), .phase_active(phase_active)
  );

  // {write mask, t1, t0, s1, s0, expected irq}
  localparam logic [66:0] VEC [NV] = '{
    {2'b00, 16'h0000, 16'h0000, 16'd5,    16'd5,    1'b0}, // R2 reset thresholds quiet
    {2'b01, 16'h0000, 16'h0000, 16'd5,    16'd5,    1'b1}, // R3 R9
    {2'b01, 16'h0000, 16'd10,   16'd5,    16'd9,    1'b0}, // R4 below
    {2'b00, 16'h0000, 16'h0000, 16'd5,    16'd10,   1'b1}, // R4 equal
    {2'b00, 16'h0000, 16'h0000, 16'd5,    16'd11,   1'b1}, // R4 above
    {2'b11, 16'd3,    16'hFFFF, 16'd2,    16'd50,   1'b0}, // R2 R4
    {2'b00, 16'h0000, 16'h0000, 16'd3,    16'd50,   1'b1}, // R5 plane1 only
    {2'b10, 16'hFFFF, 16'h0000, 16'd100,  16'd100,  1'b0}, // R2 both quiet
    {2'b01, 16'h0000, 16'hFFFE, 16'd0,    16'hFFFE, 1'b1}, // R4 top threshold
    {2'b01, 16'h0000, 16'd1,    16'd0,    16'd0,    1'b0}  // R4 R5
  };

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic clear_in();
    irq_en_cmd = 0; dis_keep_cmd = 0; dis_nophase_cmd = 0;
    tgt_wr = '0; vsync = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // one vsync with plane-0 scan id s0; returns irq seen a cycle later
  task automatic pulse_vsync(input logic [W-1:0] s0, output logic seen);
    scan_id[W-1:0] = s0; vsync = 1;
    step(); clear_in();
    seen = irq;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic seen;
    @(negedge clk); step(); rst = 0;
    chk("R1 irq reset", irq, 1'b0);
    chk("R1 phase reset", phase_active, 1'b0);

    irq_en_cmd = 1; step(); clear_in();
    chk("R8 enable sets phase", phase_active, 1'b1);

    for (int i = 0; i < NV; i++) begin
      logic [66:0] v;
      v = VEC[i];
      tgt_wr = v[66:65];
      tgt_data = {v[64:49], v[48:33]};
      scan_id = {v[32:17], v[16:1]};
      vsync = 1;
      step(); clear_in();
      chk($sformatf("R4 vector %0d", i), irq, v[0]);
      step();
      chk($sformatf("R6 pulse end %0d", i), irq, 1'b0);
    end
    // thresholds now: plane0=1, plane1=all ones

    dis_keep_cmd = 1; step(); clear_in();
    chk("R8 keep disable phase", phase_active, 1'b1);
    tgt_wr = 2'b01; tgt_data = '0; scan_id = '0; vsync = 1;
    step(); clear_in();
    chk("R7 disabled no irq", irq, 1'b0);

    irq_en_cmd = 1; vsync = 1; step(); clear_in();
    chk("R10 enable same cycle", irq, 1'b0);
    pulse_vsync(16'd0, seen);
    chk("R7 stored threshold applies", seen, 1'b1);

    dis_nophase_cmd = 1; step(); clear_in();
    chk("R8 nophase clears phase", phase_active, 1'b0);
    pulse_vsync(16'd0, seen);
    chk("R7 off no irq", seen, 1'b0);

    irq_en_cmd = 1; dis_keep_cmd = 1; step(); clear_in();
    chk("R8 keep beats enable", phase_active, 1'b0);
    irq_en_cmd = 1; step(); clear_in();
    dis_keep_cmd = 1; dis_nophase_cmd = 1; vsync = 1; step(); clear_in();
    chk("R8 nophase beats keep", phase_active, 1'b0);
    chk("R10 disable same cycle keeps old state", irq, 1'b1);

    rst = 1; step(); rst = 0;
    chk("R1 irq after reset", irq, 1'b0);
    chk("R1 phase after reset", phase_active, 1'b0);
    irq_en_cmd = 1; step(); clear_in();
    pulse_vsync(16'hFFFE, seen);
    chk("R1 thresholds quiet after reset", seen, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule